// File: doc/BRIEF.md
# Sync-Referenced Clamp Pulse Generator

This block times the internal clamp pulse of a video digitizer from the horizontal sync input. All timing is in pixel-clock cycles. A polarity select decides which level of the sync input counts as the active level, and therefore which edge is the trailing edge. When the trailing edge is seen, the block waits a programmed delay and then raises the clamp output for a programmed width. Both settings are 8-bit values, and a zero in either is read as one.

The block also drives a regenerated horizontal sync output. This output starts on the leading edge of the input sync. It ends on the trailing edge, or after half of the measured line period if no trailing edge arrives. The line period is the number of cycles between two consecutive leading edges, held in a saturating 16-bit counter.

A coast input blanks all sync edges, so that a disturbed sync stream cannot start anything. A power-down input stops both outputs and blanks the edges, while the measured line period is retained.

Top module: `clamp_pulse_gen`

## Requirements
- R1: With `sync_pol`=1 the sync is active high and its falling edge is the trailing edge. With `sync_pol`=0 the sync is active low and its rising edge is the trailing edge.
- R2: Let the trailing sync level first be sampled at clock edge t. Then `clamp_out` rises at edge t+D, where D is the delay setting (1 to 255).
- R3: `clamp_out` stays high for exactly W cycles, where W is the width setting (1 to 255).
- R4: A delay or width setting of 0 behaves exactly like a setting of 1.
- R5: A trailing edge that arrives while a delay is pending or a pulse is active restarts the sequence. The next rise then comes D cycles after the new edge, and a running pulse drops one cycle after that edge.
- R6: While `coast` is high, sync edges are ignored. No clamp sequence starts, `hsync_out` does not start and the line period is not updated.
- R7: `hsync_out` rises one edge after the leading sync level is first sampled. It falls one edge after the trailing level is first sampled.
- R8: If no trailing edge arrives, `hsync_out` stays high for floor(P/2) cycles. P is the measured line period, and P is 65535 until a period has been measured.
- R9: P is the number of cycles between the two most recent leading edges, saturating at 65535. The first leading edge after reset or power-down does not change P.
- R10: While `power_down` is high, both outputs drop one edge later and stay low, and sync edges are ignored. P is retained, and operation after release uses the same settings and the retained P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync input |
| sync_pol | input | 1 | 1: sync active high, 0: sync active low |
| clamp_delay | input | 8 | Clamp delay in pixels (0 read as 1) |
| clamp_width | input | 8 | Clamp width in pixels (0 read as 1) |
| coast | input | 1 | Ignore sync edges while high |
| power_down | input | 1 | Stop outputs and ignore edges while high |
| clamp_out | output | 1 | Internal clamp pulse |
| hsync_out | output | 1 | Regenerated horizontal sync |

## Verification
The assertions assume a few things about the inputs:
- `hsync_in` is synchronous to the pixel clock.
- A polarity change never happens together with a change of the active level, so a polarity change alone is never seen as a sync edge.
- `coast` and `power_down` change only between edges.

The stimulus follows these assumptions. Every input is driven on the falling clock edge. Whenever `sync_pol` changes, the sync input is set to the inactive level of the new polarity in the same step. During power-down the sync input is returned to its inactive level before the block is released.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_WAIT  = 2'd1,
        CS_PULSE = 2'd2
    } clamp_state_e;

    typedef struct packed {
        logic lead;
        logic trail;
    } sync_evt_t;

    // a programmed count of zero is read as one
    function automatic int unsigned floor_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/sync_edge_detect.sv
module sync_edge_detect
    import clamp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_i,
    input  logic      pol_i,
    input  logic      mask_i,
    output sync_evt_t evt_o
);
    logic act_now;
    logic act_q;
    logic act_d;

    // normalise so that 1 always means "sync active"
    assign act_now = pol_i ? sync_i : ~sync_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            act_d <= 1'b0;
        end else begin
            act_q <= act_now;
            act_d <= act_q;
        end
    end

    always_comb begin
        evt_o.lead  = act_q & ~act_d & ~mask_i;
        evt_o.trail = ~act_q & act_d & ~mask_i;
    end

endmodule

// File: rtl/line_period_meter.sv
module line_period_meter #(
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_i,
    input  logic              lead_i,
    output logic [LINE_W-1:0] period_o
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    logic [LINE_W-1:0] run_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= '0;
            period_o <= LINE_MAX;
            valid_q  <= 1'b0;
        end else if (pd_i) begin
            valid_q <= 1'b0;
        end else if (lead_i) begin
            if (valid_q) begin
                period_o <= run_q;
            end
            valid_q <= 1'b1;
            run_q   <= LINE_W'(1);
        end else if (run_q != LINE_MAX) begin
            run_q <= run_q + LINE_W'(1);
        end
    end

    assert_period_on_lead_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(period_o) |-> $past(lead_i));

    assert_run_saturates_R9: assert property (@(posedge clk) disable iff (rst)
        (run_q == LINE_MAX && !lead_i) |=> (run_q == LINE_MAX));

endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
    import clamp_pkg::*;
#(
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_i,
    input  sync_evt_t         evt_i,
    input  logic [LINE_W-1:0] period_i,
    output logic              hs_o
);
    logic [LINE_W-1:0] half_len;
    logic [LINE_W-1:0] high_cnt_q;

    assign half_len = period_i >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_o       <= 1'b0;
            high_cnt_q <= '0;
        end else if (pd_i) begin
            hs_o <= 1'b0;
        end else if (evt_i.lead) begin
            hs_o       <= 1'b1;
            high_cnt_q <= LINE_W'(1);
        end else if (hs_o) begin
            if (evt_i.trail || high_cnt_q >= half_len) begin
                hs_o <= 1'b0;
            end else begin
                high_cnt_q <= high_cnt_q + LINE_W'(1);
            end
        end
    end

    assert_lead_starts_R7: assert property (@(posedge clk) disable iff (rst)
        (evt_i.lead && !pd_i) |=> hs_o);

    assert_trail_ends_R7: assert property (@(posedge clk) disable iff (rst)
        (evt_i.trail && !pd_i) |=> !hs_o);

    assert_hs_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        pd_i |=> !hs_o);

endmodule

// File: rtl/clamp_sequencer.sv
module clamp_sequencer
    import clamp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_i,
    input  logic             trail_i,
    input  logic [CNT_W-1:0] dly_i,
    input  logic [CNT_W-1:0] wid_i,
    output logic             clamp_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    clamp_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] dly_eff;
    logic [CNT_W-1:0] wid_eff;

    assign dly_eff = CNT_W'(floor_one(32'(dly_i)));
    assign wid_eff = CNT_W'(floor_one(32'(wid_i)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_IDLE;
            cnt_q   <= '0;
        end else if (pd_i) begin
            state_q <= CS_IDLE;
        end else if (trail_i) begin
            // the edge detector costs one cycle, so the wait is preloaded with D-2
            if (dly_eff == ONE) begin
                state_q <= CS_PULSE;
                cnt_q   <= wid_eff - ONE;
            end else begin
                state_q <= CS_WAIT;
                cnt_q   <= dly_eff - TWO;
            end
        end else begin
            unique case (state_q)
                CS_WAIT: begin
                    if (cnt_q == '0) begin
                        state_q <= CS_PULSE;
                        cnt_q   <= wid_eff - ONE;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                CS_PULSE: begin
                    if (cnt_q == '0) begin
                        state_q <= CS_IDLE;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    assign clamp_o = (state_q == CS_PULSE);

    assert_first_step_R2: assert property (@(posedge clk) disable iff (rst)
        (trail_i && !pd_i) |=> (clamp_o == ($past(dly_eff) == ONE)));

    assert_clamp_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        pd_i |=> !clamp_o);

    assert_pulse_needs_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(clamp_o) |-> ($past(state_q) == CS_WAIT || $past(trail_i)));

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
    import clamp_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LINE_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_in,
    input  logic             sync_pol,
    input  logic [CNT_W-1:0] clamp_delay,
    input  logic [CNT_W-1:0] clamp_width,
    input  logic             coast,
    input  logic             power_down,
    output logic             clamp_out,
    output logic             hsync_out
);
    sync_evt_t         evt;
    logic              evt_mask;
    logic [LINE_W-1:0] line_period;

    assign evt_mask = coast | power_down;

    sync_edge_detect u_edge (
        .clk    (clk),
        .rst    (rst),
        .sync_i (hsync_in),
        .pol_i  (sync_pol),
        .mask_i (evt_mask),
        .evt_o  (evt)
    );

    line_period_meter #(.LINE_W(LINE_W)) u_period (
        .clk      (clk),
        .rst      (rst),
        .pd_i     (power_down),
        .lead_i   (evt.lead),
        .period_o (line_period)
    );

    hsync_regen #(.LINE_W(LINE_W)) u_hsync (
        .clk      (clk),
        .rst      (rst),
        .pd_i     (power_down),
        .evt_i    (evt),
        .period_i (line_period),
        .hs_o     (hsync_out)
    );

    clamp_sequencer #(.CNT_W(CNT_W)) u_clamp (
        .clk     (clk),
        .rst     (rst),
        .pd_i    (power_down),
        .trail_i (evt.trail),
        .dly_i   (clamp_delay),
        .wid_i   (clamp_width),
        .clamp_o (clamp_out)
    );

    assert_coast_keeps_period_R6: assert property (@(posedge clk) disable iff (rst)
        coast |=> $stable(line_period));

    assert_coast_no_hs_start_R6: assert property (@(posedge clk) disable iff (rst)
        (coast && !hsync_out) |=> !hsync_out);

endmodule

// File: tb/clamp_pulse_gen_tb.sv
module clamp_pulse_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hs_in = 1'b0;
    logic       pol = 1'b1;
    logic [7:0] dly = 8'd1;
    logic [7:0] wid = 8'd1;
    logic       coast = 1'b0;
    logic       pd = 1'b0;
    logic       clamp;
    logic       hs_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    clamp_pulse_gen dut_i (
        .clk (clk), .rst (rst), .hsync_in (hs_in), .sync_pol (pol),
        .clamp_delay (dly), .clamp_width (wid), .coast (coast),
        .power_down (pd), .clamp_out (clamp), .hsync_out (hs_out)
    );

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_sync(input bit active);
        @(negedge clk);
        hs_in = pol ? active : ~active;
    endtask

    task automatic set_pol(input bit p);
        @(negedge clk);
        pol   = p;
        hs_in = p ? 1'b0 : 1'b1;
    endtask

    task automatic measure_clamp(input int limit, output int first, output int len);
        first = -1;
        len   = 0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i >= 1) begin
                if (clamp) begin
                    if (first < 0) first = i;
                    len++;
                end else if (first >= 0) begin
                    break;
                end
            end
        end
    endtask

    task automatic count_hs(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (hs_out) n++;
            else if (n > 0) break;
        end
    endtask

    task automatic lead_line(input int gap);
        drive_sync(1'b1);
        repeat (4) @(negedge clk);
        drive_sync(1'b0);
        repeat (gap - 6) @(negedge clk);
    endtask

    task automatic clamp_run(input int d, input int w);
        int first, len;
        @(negedge clk);
        dly = 8'(d);
        wid = 8'(w);
        drive_sync(1'b1);
        repeat (3) @(negedge clk);
        drive_sync(1'b0);
        measure_clamp(eff(d) + eff(w) + 8, first, len);
        chk(first == eff(d), (d == 0) ? "R4 delay" : (pol ? "R2 pol1" : "R1 pol0 delay"), first, eff(d));
        chk(len == eff(w), (w == 0) ? "R4 width" : "R3", len, eff(w));
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        int first, len, n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(clamp == 1'b0, "reset clamp", int'(clamp), 0);
        chk(hs_out == 1'b0, "reset hsync", int'(hs_out), 0);

        // R8: no period measured yet, timeout is 65535/2
        drive_sync(1'b1);
        count_hs(40000, n);
        chk(n == 32767, "R8 initial timeout", n, 32767);
        drive_sync(1'b0);
        repeat (10) @(negedge clk);

        // R7: edge latency of the regenerated sync
        drive_sync(1'b1);
        @(posedge clk); @(negedge clk);
        chk(hs_out == 1'b0, "R7 before rise", int'(hs_out), 0);
        @(posedge clk); @(negedge clk);
        chk(hs_out == 1'b1, "R7 rise", int'(hs_out), 1);
        drive_sync(1'b0);
        @(posedge clk); @(negedge clk);
        chk(hs_out == 1'b1, "R7 before fall", int'(hs_out), 1);
        @(posedge clk); @(negedge clk);
        chk(hs_out == 1'b0, "R7 fall", int'(hs_out), 0);
        repeat (10) @(negedge clk);

        // R1-R4 sweeps for both polarities
        for (int p = 1; p >= 0; p--) begin
            set_pol(p[0]);
            for (int d = 0; d <= 20; d++) clamp_run(d, 3);
            for (int d = 250; d <= 255; d++) clamp_run(d, 3);
            for (int w = 0; w <= 20; w++) clamp_run(2, w);
            for (int w = 250; w <= 255; w++) clamp_run(2, w);
        end
        set_pol(1'b1);

        // R5: restart during a pending delay
        @(negedge clk); dly = 8'd10; wid = 8'd5;
        drive_sync(1'b1); repeat (2) @(negedge clk); drive_sync(1'b0);
        repeat (4) @(negedge clk);
        drive_sync(1'b1); repeat (2) @(negedge clk); drive_sync(1'b0);
        measure_clamp(30, first, len);
        chk(first == 10, "R5 restart in delay start", first, 10);
        chk(len == 5, "R5 restart in delay width", len, 5);
        repeat (5) @(negedge clk);

        // R5: restart during an active pulse
        @(negedge clk); dly = 8'd3; wid = 8'd20;
        drive_sync(1'b1); repeat (2) @(negedge clk); drive_sync(1'b0);
        repeat (8) @(negedge clk);
        drive_sync(1'b1); repeat (2) @(negedge clk); drive_sync(1'b0);
        measure_clamp(40, first, len);
        chk(first == 3, "R5 restart in pulse start", first, 3);
        chk(len == 20, "R5 restart in pulse width", len, 20);
        repeat (5) @(negedge clk);

        // R8/R9: measured period, timeout is half of it
        @(negedge clk); dly = 8'd1; wid = 8'd1;
        for (int k = 0; k < 3; k++) lead_line(37);
        drive_sync(1'b1);
        count_hs(100, n);
        chk(n == 18, "R8 timeout P=37", n, 18);
        drive_sync(1'b0);
        repeat (10) @(negedge clk);

        // R6: coast ignores edges
        @(negedge clk); coast = 1'b1; dly = 8'd5; wid = 8'd5;
        drive_sync(1'b1);
        begin
            int seen = 0;
            for (int i = 0; i < 4; i++) begin
                @(posedge clk); @(negedge clk);
                if (hs_out) seen++;
            end
            chk(seen == 0, "R6 coast hsync", seen, 0);
        end
        drive_sync(1'b0);
        measure_clamp(25, first, len);
        chk(len == 0, "R6 coast clamp", len, 0);
        @(negedge clk); coast = 1'b0;
        repeat (5) @(negedge clk);

        // R10: power-down during a pending delay, period kept
        @(negedge clk); dly = 8'd50; wid = 8'd10;
        for (int k = 0; k < 3; k++) lead_line(40);
        drive_sync(1'b1);
        repeat (2) @(negedge clk);
        drive_sync(1'b0);
        repeat (5) @(negedge clk);
        pd = 1'b1;
        begin
            int seen_c = 0, seen_h = 0;
            for (int i = 0; i < 80; i++) begin
                @(posedge clk); @(negedge clk);
                if (clamp) seen_c++;
                if (hs_out) seen_h++;
                if (i == 10) hs_in = 1'b1;
                if (i == 20) hs_in = 1'b0;
            end
            chk(seen_c == 0, "R10 clamp held low", seen_c, 0);
            chk(seen_h == 0, "R10 hsync held low", seen_h, 0);
        end
        @(negedge clk); pd = 1'b0;
        repeat (3) @(negedge clk);
        drive_sync(1'b1);
        count_hs(100, n);
        chk(n == 20, "R10 R9 period kept", n, 20);
        drive_sync(1'b0);
        measure_clamp(80, first, len);
        chk(first == 50, "R10 delay after release", first, 50);
        chk(len == 10, "R10 width after release", len, 10);
        repeat (5) @(negedge clk);

        // R10: power-down drops a high hsync one edge later
        drive_sync(1'b1);
        repeat (3) @(negedge clk);
        chk(hs_out == 1'b1, "R10 hsync high before pd", int'(hs_out), 1);
        pd = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(hs_out == 1'b0, "R10 hsync dropped", int'(hs_out), 0);
        hs_in = 1'b0;
        repeat (2) @(negedge clk);
        pd = 1'b0;
        repeat (5) @(negedge clk);

        // R9: saturation of the line counter
        @(negedge clk); dly = 8'd1; wid = 8'd1;
        lead_line(66000);
        drive_sync(1'b1);
        count_hs(40000, n);
        chk(n == 32767, "R9 saturated period", n, 32767);
        drive_sync(1'b0);
        repeat (5) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule